// File: doc/BRIEF.md
# Sector Write-Protect Unlock Sequencer

This block watches the completed cycles of a byte-wide memory port and decides which of eight equal sectors of a 17-bit address space may be written. The bus front end hands it one strobe per finished cycle, together with the direction, the address, the write data and a flag that tells whether the cycle opened with a fresh chip-enable falling edge. Protection can only be changed by a fixed run of six reads at secret addresses, then a write carrying the new protection byte, then a write carrying its bitwise complement. Any slip sends the detector back to its start with the protection untouched.

During the key the reads are ordinary reads and the array still serves their data. The two data writes of the sequence are flagged so that the front end does not store them. Every write that falls in a protected sector is flagged as inhibited in the same cycle. The protection value sits in a plain register that resets to zero, which stands in for nonvolatile storage.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset, or after reset is applied in the middle of a sequence, `prot_o` is 00h, `prot_upd_o` is 0, and the detector is back at its start state.
- R2: Six reads in this order: 05555h, 1AAAAh, 03333h, 1CCCCh, 100FFh, 0FF00h. They are followed by a write of byte P at any address and then a write of ~P. This sequence sets `prot_o` to P.
- R3: A read whose address is not the next key address sends the detector back to the start. A seventh read where the byte write is due does the same. Neither changes `prot_o`, and the writes that follow are not treated as sequence writes.
- R4: If the write after the protection byte does not carry its exact bitwise complement, the attempt is abandoned, `prot_o` keeps its value and detection starts over.
- R5: `seq_wr_o` is 1 during the strobe of the byte write and of the complement write, whether or not the complement matches. It is 0 for every other cycle. The address of these writes plays no part.
- R6: `wr_inhibit_o` is 1 during a write strobe whose sector, given by address bits [16:14], has its bit set in `prot_o` (bit n covers sector n). It is 0 for reads and for writes to unprotected sectors.
- R7: The first key read at 05555h is accepted only in one of two cases: `cyc_fresh_i` is 1 for that cycle, or the previous completed cycle was a read of 00000h.
- R8: `prot_upd_o` is 1 for exactly the one clock cycle after the strobe of a matching complement write. `prot_o` shows the new value in that same cycle.
- R9: A cycle that breaks the sequence is itself evaluated as a possible first key read, so a read at 05555h that breaks a partial key starts a new attempt.
- R10: Clock cycles without `cyc_done_i` leave the detector state unchanged, so idle gaps between cycles do not disturb a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_done_i | input | 1 | One-cycle strobe: a memory cycle has completed |
| cyc_we_i | input | 1 | Completed cycle was a write (1) or a read (0) |
| cyc_fresh_i | input | 1 | Completed cycle began with a chip-enable falling edge |
| cyc_addr_i | input | 17 | Byte address of the completed cycle |
| cyc_wdata_i | input | 8 | Write data of the completed cycle |
| wr_inhibit_o | output | 1 | Current write strobe targets a protected sector |
| seq_wr_o | output | 1 | Current write strobe belongs to the sequence and must not be stored |
| prot_o | output | 8 | Per-sector protect register, bit n for sector n |
| prot_upd_o | output | 1 | One-cycle pulse after a new protection value is committed |

## Verification
The bench goes after keys that are broken in several ways: a skipped key address, a seventh read where the byte write is due, a wrong complement, and a first key read that arrives without a fresh chip enable. A design that resynchronised too loosely would unlock on one of these and change `prot_o`. A design that ignored the fresh-enable rule would flag the following writes with `seq_wr_o` and swallow data. The bench also breaks a partial key with 05555h. A design that did not re-evaluate the breaking cycle would miss the unlock that follows. Idle gaps placed inside a key check that nothing advances without a strobe. The inhibit output is sampled for every sector class before and after protection changes, so a wrong sector decode shows up as an inhibit on the wrong block.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;
  localparam int unsigned ADDR_W  = 17;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SECT_N  = 8;
  localparam int unsigned KEY_LEN = 6;
  localparam int unsigned SECT_W  = $clog2(SECT_N);
  localparam int unsigned IDX_W   = $clog2(KEY_LEN);

  typedef enum logic [1:0] {
    ST_KEY  = 2'd0,
    ST_BYTE = 2'd1,
    ST_CPL  = 2'd2
  } wp_state_e;

  // Key addresses in the order they must be read
  function automatic logic [ADDR_W-1:0] key_addr(input int unsigned i);
    case (i)
      0:       key_addr = 17'h05555;
      1:       key_addr = 17'h1AAAA;
      2:       key_addr = 17'h03333;
      3:       key_addr = 17'h1CCCC;
      4:       key_addr = 17'h100FF;
      5:       key_addr = 17'h0FF00;
      default: key_addr = '0;
    endcase
  endfunction
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match
  import wp_unlock_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_cur_o,
  output logic              hit_first_o,
  output logic              is_zero_o
);
  localparam int unsigned IDX_N = 1 << IDX_W;

  logic [IDX_N-1:0] hit_vec;

  // One comparator per key slot; unused slots never match
  for (genvar k = 0; k < IDX_N; k++) begin : g_cmp
    if (k < KEY_LEN) begin : g_key
      assign hit_vec[k] = (addr_i == key_addr(k));
    end else begin : g_pad
      assign hit_vec[k] = 1'b0;
    end
  end

  assign hit_cur_o   = hit_vec[idx_i];
  assign hit_first_o = hit_vec[0];
  assign is_zero_o   = (addr_i == '0);
endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
  import wp_unlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_done_i,
  input  logic              cyc_we_i,
  input  logic              cyc_fresh_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic [DATA_W-1:0] cyc_wdata_i,
  output logic              seq_wr_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] commit_data_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(KEY_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  wp_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] held_q, held_d;
  logic              zero_q;
  logic              hit_cur, hit_first, is_zero;
  logic              start_ok, cur_ok;

  wp_key_match u_match (
    .idx_i      (idx_q),
    .addr_i     (cyc_addr_i),
    .hit_cur_o  (hit_cur),
    .hit_first_o(hit_first),
    .is_zero_o  (is_zero)
  );

  // First key read needs a fresh enable or a preceding read of address zero
  assign start_ok = !cyc_we_i && hit_first && (cyc_fresh_i || zero_q);
  assign cur_ok   = !cyc_we_i && hit_cur && ((idx_q != '0) || cyc_fresh_i || zero_q);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    held_d   = held_q;
    commit_o = 1'b0;
    if (cyc_done_i) begin
      unique case (state_q)
        ST_KEY: begin
          if (cur_ok) begin
            if (idx_q == IDX_LAST) begin
              state_d = ST_BYTE;
              idx_d   = '0;
            end else begin
              idx_d = idx_q + IDX_ONE;
            end
          end else begin
            idx_d = start_ok ? IDX_ONE : '0;
          end
        end
        ST_BYTE: begin
          if (cyc_we_i) begin
            held_d  = cyc_wdata_i;
            state_d = ST_CPL;
          end else begin
            state_d = ST_KEY;
            idx_d   = start_ok ? IDX_ONE : '0;
          end
        end
        ST_CPL: begin
          state_d  = ST_KEY;
          commit_o = cyc_we_i && (cyc_wdata_i == ~held_q);
          idx_d    = start_ok ? IDX_ONE : '0;
        end
        default: begin
          state_d = ST_KEY;
          idx_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_KEY;
      idx_q   <= '0;
      held_q  <= '0;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      held_q  <= held_d;
      if (cyc_done_i) zero_q <= !cyc_we_i && is_zero;
    end
  end

  assign seq_wr_o      = cyc_done_i && cyc_we_i && (state_q != ST_KEY);
  assign commit_data_o = held_q;

  assert_byte_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_BYTE) |-> $past(cyc_done_i && !cyc_we_i && (cyc_addr_i == key_addr(KEY_LEN - 1))));

  assert_seq_wr_is_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_wr_o |-> (cyc_done_i && cyc_we_i));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_done_i |=> ($stable(state_q) && $stable(idx_q)));
endmodule

// File: rtl/wp_prot_reg.sv
module wp_prot_reg
  import wp_unlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] commit_data_i,
  input  logic              wr_strobe_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic [SECT_N-1:0] prot_o,
  output logic              upd_o,
  output logic              inhibit_o
);
  logic [SECT_N-1:0] prot_q;
  logic [SECT_N-1:0] sect_dec;
  logic              upd_q;

  for (genvar s = 0; s < SECT_N; s++) begin : g_dec
    assign sect_dec[s] = (sect_i == SECT_W'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= commit_i;
      if (commit_i) prot_q <= SECT_N'(commit_data_i);
    end
  end

  assign prot_o    = prot_q;
  assign upd_o     = upd_q;
  assign inhibit_o = wr_strobe_i && |(sect_dec & prot_q);

  assert_prot_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |-> $stable(prot_q));

  assert_inh_write_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o |-> wr_strobe_i);
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_unlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_done_i,
  input  logic              cyc_we_i,
  input  logic              cyc_fresh_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic [DATA_W-1:0] cyc_wdata_i,
  output logic              wr_inhibit_o,
  output logic              seq_wr_o,
  output logic [SECT_N-1:0] prot_o,
  output logic              prot_upd_o
);
  logic              commit;
  logic [DATA_W-1:0] commit_data;

  wp_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_done_i   (cyc_done_i),
    .cyc_we_i     (cyc_we_i),
    .cyc_fresh_i  (cyc_fresh_i),
    .cyc_addr_i   (cyc_addr_i),
    .cyc_wdata_i  (cyc_wdata_i),
    .seq_wr_o     (seq_wr_o),
    .commit_o     (commit),
    .commit_data_o(commit_data)
  );

  wp_prot_reg u_prot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .commit_data_i(commit_data),
    .wr_strobe_i  (cyc_done_i && cyc_we_i),
    .sect_i       (cyc_addr_i[ADDR_W-1 -: SECT_W]),
    .prot_o       (prot_o),
    .upd_o        (prot_upd_o),
    .inhibit_o    (wr_inhibit_o)
  );

  assert_upd_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_upd_o |-> (prot_o == SECT_N'(~$past(cyc_wdata_i))));

  assert_upd_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_upd_o |=> !prot_upd_o);
endmodule

// File: tb/wp_unlock_seq_tb.sv
module wp_unlock_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done = 1'b0, we = 1'b0, fresh = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wd = '0;
  logic        inh, supp, upd;
  logic [7:0]  prot;

  int n_tot = 0, n_bad = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  wp_unlock_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_done_i(done), .cyc_we_i(we),
    .cyc_fresh_i(fresh), .cyc_addr_i(addr), .cyc_wdata_i(wd),
    .wr_inhibit_o(inh), .seq_wr_o(supp), .prot_o(prot), .prot_upd_o(upd)
  );

  typedef struct packed {
    logic        we, fresh, gap;
    logic [16:0] addr;
    logic [7:0]  wd;
    logic        supp, inh, upd;
    logic [7:0]  prot;
  } vec_t;

  function automatic vec_t v(logic w, logic f, logic g, logic [16:0] a, logic [7:0] d,
                             logic s, logic i, logic u, logic [7:0] p);
    v = '{we:w, fresh:f, gap:g, addr:a, wd:d, supp:s, inh:i, upd:u, prot:p};
  endfunction

  localparam int NV = 64;
  localparam vec_t VEC [NV] = '{
    // R2 R5 R8: unlock to 13h, address of byte write ignored
    v(0,1,0,17'h05555,8'h00,0,0,0,8'h00), v(0,0,0,17'h1AAAA,8'h00,0,0,0,8'h00),
    v(0,0,0,17'h03333,8'h00,0,0,0,8'h00), v(0,0,0,17'h1CCCC,8'h00,0,0,0,8'h00),
    v(0,0,0,17'h100FF,8'h00,0,0,0,8'h00), v(0,0,0,17'h0FF00,8'h00,0,0,0,8'h00),
    v(1,0,0,17'h12345,8'h13,1,0,0,8'h00), v(1,0,0,17'h00000,8'hEC,1,0,1,8'h13),
    // R6: sector inhibit with 13h
    v(1,0,0,17'h04000,8'h55,0,1,0,8'h13), v(1,0,0,17'h08000,8'h55,0,0,0,8'h13),
    v(0,0,0,17'h10000,8'h00,0,0,0,8'h13), v(1,0,0,17'h13FFF,8'h55,0,1,0,8'h13),
    // R3: skipped key address
    v(0,1,0,17'h05555,8'h00,0,0,0,8'h13), v(0,0,0,17'h03333,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h1CCCC,8'h00,0,0,0,8'h13), v(0,0,0,17'h100FF,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h0FF00,8'h00,0,0,0,8'h13), v(1,0,0,17'h08000,8'hFF,0,0,0,8'h13),
    // R3: seventh read
    v(0,1,0,17'h05555,8'h00,0,0,0,8'h13), v(0,0,0,17'h1AAAA,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h03333,8'h00,0,0,0,8'h13), v(0,0,0,17'h1CCCC,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h100FF,8'h00,0,0,0,8'h13), v(0,0,0,17'h0FF00,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h0FF00,8'h00,0,0,0,8'h13), v(1,0,0,17'h08000,8'h5A,0,0,0,8'h13),
    v(1,0,0,17'h08000,8'hA5,0,0,0,8'h13),
    // R4: wrong complement
    v(0,1,0,17'h05555,8'h00,0,0,0,8'h13), v(0,0,0,17'h1AAAA,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h03333,8'h00,0,0,0,8'h13), v(0,0,0,17'h1CCCC,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h100FF,8'h00,0,0,0,8'h13), v(0,0,0,17'h0FF00,8'h00,0,0,0,8'h13),
    v(1,0,0,17'h08000,8'h0F,1,0,0,8'h13), v(1,0,0,17'h08000,8'hF1,1,0,0,8'h13),
    // R7: no fresh enable, no preceding zero read -> not accepted
    v(0,0,0,17'h05555,8'h00,0,0,0,8'h13), v(0,0,0,17'h1AAAA,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h03333,8'h00,0,0,0,8'h13), v(0,0,0,17'h1CCCC,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h100FF,8'h00,0,0,0,8'h13), v(0,0,0,17'h0FF00,8'h00,0,0,0,8'h13),
    v(1,0,0,17'h08000,8'h00,0,0,0,8'h13),
    // R7: zero read arms the key
    v(0,0,0,17'h00000,8'h00,0,0,0,8'h13), v(0,0,0,17'h05555,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h1AAAA,8'h00,0,0,0,8'h13), v(0,0,0,17'h03333,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h1CCCC,8'h00,0,0,0,8'h13), v(0,0,0,17'h100FF,8'h00,0,0,0,8'h13),
    v(0,0,0,17'h0FF00,8'h00,0,0,0,8'h13), v(1,0,0,17'h08000,8'h81,1,0,0,8'h13),
    v(1,0,0,17'h08000,8'h7E,1,0,1,8'h81),
    // R6 with 81h
    v(1,0,0,17'h1C000,8'h11,0,1,0,8'h81), v(1,0,0,17'h00010,8'h11,0,1,0,8'h81),
    // R9 restart on 05555h, R10 idle gaps inside the key
    v(0,1,0,17'h05555,8'h00,0,0,0,8'h81), v(0,1,0,17'h1AAAA,8'h00,0,0,0,8'h81),
    v(0,1,0,17'h05555,8'h00,0,0,0,8'h81), v(0,0,1,17'h1AAAA,8'h00,0,0,0,8'h81),
    v(0,0,1,17'h03333,8'h00,0,0,0,8'h81), v(0,0,0,17'h1CCCC,8'h00,0,0,0,8'h81),
    v(0,0,1,17'h100FF,8'h00,0,0,0,8'h81), v(0,0,0,17'h0FF00,8'h00,0,0,0,8'h81),
    v(1,0,1,17'h1C000,8'h00,1,1,0,8'h81), v(1,0,0,17'h00000,8'hFF,1,1,1,8'h00),
    v(1,0,0,17'h1C000,8'h22,0,0,0,8'h00)
  };

  logic s_supp, s_inh, s_upd;
  logic [7:0] s_prot;

  task automatic chk(input string tag, input int idx, input logic [7:0] act, input logic [7:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s step %0d: actual %0h expected %0h", tag, idx, act, exp);
    end
  endtask

  task automatic run_cyc(input logic w, input logic f, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    done = 1'b1; we = w; fresh = f; addr = a; wd = d;
    #1;
    s_supp = supp; s_inh = inh;
    @(posedge clk);
    #1;
    s_upd = upd; s_prot = prot;
    done = 1'b0; we = 1'b0; fresh = 1'b0;
  endtask

  task automatic key(input logic f);
    run_cyc(0, f, 17'h05555, 8'h00); run_cyc(0, 0, 17'h1AAAA, 8'h00);
    run_cyc(0, 0, 17'h03333, 8'h00); run_cyc(0, 0, 17'h1CCCC, 8'h00);
    run_cyc(0, 0, 17'h100FF, 8'h00); run_cyc(0, 0, 17'h0FF00, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    if (!fin) begin
      fin = 1;
      n_tot++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset prot", 0, prot, 8'h00);
    chk("R1 reset upd", 0, {7'd0, upd}, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].gap) repeat (3) @(posedge clk);
      run_cyc(VEC[i].we, VEC[i].fresh, VEC[i].addr, VEC[i].wd);
      chk("R5 seq_wr", i, {7'd0, s_supp}, {7'd0, VEC[i].supp});
      chk("R6 inhibit", i, {7'd0, s_inh}, {7'd0, VEC[i].inh});
      chk("R8 upd pulse", i, {7'd0, s_upd}, {7'd0, VEC[i].upd});
      chk("R2 prot", i, s_prot, VEC[i].prot);
    end

    // R8: pulse lasts one cycle
    @(posedge clk); #1;
    chk("R8 pulse width", 100, {7'd0, upd}, 8'h00);

    // R2: set 24h, then R1 reset mid-key
    key(1'b1);
    run_cyc(1, 0, 17'h1FFFF, 8'h24);
    run_cyc(1, 0, 17'h1FFFF, 8'hDB);
    chk("R2 prot 24h", 101, s_prot, 8'h24);
    chk("R8 upd 24h", 102, {7'd0, s_upd}, 8'h01);
    run_cyc(1, 0, 17'h14000, 8'h00);
    chk("R6 sector5", 103, {7'd0, s_inh}, 8'h01);
    run_cyc(0, 1, 17'h05555, 8'h00);
    run_cyc(0, 0, 17'h1AAAA, 8'h00);
    run_cyc(0, 0, 17'h03333, 8'h00);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 mid reset prot", 104, prot, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    run_cyc(0, 0, 17'h1CCCC, 8'h00); run_cyc(0, 0, 17'h100FF, 8'h00);
    run_cyc(0, 0, 17'h0FF00, 8'h00);
    run_cyc(1, 0, 17'h08000, 8'h0F);
    chk("R1 restart after reset", 105, {7'd0, s_supp}, 8'h00);
    chk("R1 prot stays", 106, s_prot, 8'h00);

    if (!fin) begin
      fin = 1;
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
    end
  end
endmodule